// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It does this by reading two levels of translation entries from memory. A requester presents a linear address together with a write flag and a user-privilege flag. The walker reads the directory entry, then the page-table entry, and writes either entry back when the accessed or dirty flag has to change. It then returns either the physical address or a page fault. A fault carries a protection/not-present indication. The faulting linear address stays in a register that software can read.

A single 32-bit memory port carries every access. The port holds its request until the memory acknowledges it. The walker handles one translation at a time. When translation is switched off, the request is answered directly with the unchanged address and memory is not touched.

Top module: `xlate_walker`

## Requirements
- R1: The directory entry is read at {dir_base[31:12], lin[31:22], 2'b00}, and the table entry is read at {directory_entry[31:12], lin[21:12], 2'b00}.
- R2: A successful translation returns rsp_phys = {table_entry[31:12], lin[11:0]} with rsp_fault = 0.
- R3: If bit 0 (present) of either entry is 0, the walk stops with no further memory access. The response has rsp_fault = 1, rsp_prot = 0 and rsp_vector = 14. rsp_vector is 0 on any non-fault response.
- R4: fault_lin takes the request's linear address when a fault is answered. It keeps that value through later successful translations and is 0 after reset.
- R5: With pg_en = 0 at acceptance, the response arrives in the next cycle with rsp_phys equal to the linear address and no memory access.
- R6: Bit 5 (accessed) is set in every entry the walk uses and is never cleared.
- R7: Bit 6 (dirty) is set in the table entry only, and only on a write request. Directory entries never receive it.
- R8: An entry is written back, to the address it was read from, only when its value changes. Each walk follows the order: directory read, optional directory write, table read, optional table write.
- R9: For req_user = 1, the access needs bit 2 (user) set in both entries, and a write also needs bit 1 (writable) set in both. A violation gives rsp_fault = 1, rsp_prot = 1, rsp_vector = 14, and no table write-back. For req_user = 0, bits 1 and 2 are ignored.
- R10: req_ready is high only while the walker is idle, and the memory port is quiet while it is idle.
- R11: After reset: req_ready = 1, rsp_valid = 0, mem_req = 0, fault_lin = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_en | input | 1 | Translation enable, sampled at request acceptance |
| dir_base | input | 32 | Directory base; bits 31:12 used |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access at user privilege |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_prot | output | 1 | Fault is a protection violation |
| rsp_vector | output | 8 | Exception vector, 14 on fault |
| fault_lin | output | 32 | Last faulting linear address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_rdata | input | 32 | Entry read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
The bench replays a sequence where entry flags change between requests. A first touch must cost a write-back. A repeat must not: an always-write design shows extra accesses. A write to a clean page must set the dirty flag only in the table entry; a design that dirties the directory is caught by a memory readback. Faults at each level are checked by access count, to confirm that a directory fault issues no table read. A user write to a read-only page and a supervisor write to the same page must resolve differently. The bench also checks that the fault address survives later good translations and that disabled paging never touches memory.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int VEC_W  = 8;
    localparam int BASE_W = ADDR_W - OFF_W;

    localparam int FL_PRESENT = 0;
    localparam int FL_WRITE   = 1;
    localparam int FL_USER    = 2;
    localparam int FL_ACCESS  = 5;
    localparam int FL_DIRTY   = 6;

    localparam logic [VEC_W-1:0] FAULT_VECTOR = VEC_W'(14);

    typedef enum logic [2:0] {
        ST_IDLE, ST_DRD, ST_DWR, ST_TRD, ST_TWR, ST_RESP
    } walk_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] lin;
        logic              wr;
        logic              user;
    } walk_req_t;

    typedef struct packed {
        logic              fault;
        logic              prot;
        logic [ADDR_W-1:0] phys;
    } walk_res_t;

    function automatic logic [ADDR_W-1:0] slot_addr(
        input logic [ADDR_W-1:0] base,
        input logic [IDX_W-1:0]  idx
    );
        return {base[ADDR_W-1:OFF_W], idx, 2'b00};
    endfunction
endpackage

// File: rtl/xlate_entry_eval.sv
module xlate_entry_eval
    import xlate_pkg::*;
#(
    parameter bit IS_LEAF = 1'b0
) (
    input  logic [ADDR_W-1:0] entry,
    input  logic              wr,
    output logic              present,
    output logic [ADDR_W-1:0] upd,
    output logic              changed
);
    logic [ADDR_W-1:0] marked;

    always_comb begin
        marked            = entry;
        marked[FL_ACCESS] = 1'b1;
    end

    generate
        if (IS_LEAF) begin : g_leaf
            always_comb begin
                upd = marked;
                if (wr) upd[FL_DIRTY] = 1'b1;
            end
        end else begin : g_dir
            assign upd = marked;
        end
    endgenerate

    assign present = entry[FL_PRESENT];
    assign changed = (upd != entry);
endmodule

// File: rtl/xlate_perm.sv
module xlate_perm
    import xlate_pkg::*;
(
    input  logic              user,
    input  logic              wr,
    input  logic [ADDR_W-1:0] dir_ent,
    input  logic [ADDR_W-1:0] tab_ent,
    output logic              deny
);
    logic user_ok;
    logic write_ok;

    always_comb begin
        user_ok  = dir_ent[FL_USER] & tab_ent[FL_USER];
        write_ok = dir_ent[FL_WRITE] & tab_ent[FL_WRITE];
        deny     = user & (~user_ok | (wr & ~write_ok));
    end
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
    import xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pg_en,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_lin,
    input  logic              req_write,
    input  logic              req_user,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              pde_present,
    input  logic [ADDR_W-1:0] pde_upd,
    input  logic              pde_chg,
    input  logic              pte_present,
    input  logic [ADDR_W-1:0] pte_upd,
    input  logic              pte_chg,
    input  logic              perm_deny,
    output logic              wr_q,
    output logic              user_q,
    output logic [ADDR_W-1:0] pde_q,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_phys,
    output logic              rsp_fault,
    output logic              rsp_prot,
    output logic [VEC_W-1:0]  rsp_vector,
    output logic [ADDR_W-1:0] fault_lin
);
    walk_st_e          st_q;
    walk_req_t         rq_q;
    walk_res_t         res_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] pte_q;
    logic [ADDR_W-1:0] flt_q;
    logic [ADDR_W-1:0] dir_slot;
    logic [ADDR_W-1:0] tab_slot;

    assign dir_slot = slot_addr(base_q, rq_q.lin[ADDR_W-1 -: IDX_W]);
    assign tab_slot = slot_addr(pde_q,  rq_q.lin[OFF_W+IDX_W-1 -: IDX_W]);

    always_comb begin
        mem_req   = (st_q == ST_DRD) || (st_q == ST_DWR) ||
                    (st_q == ST_TRD) || (st_q == ST_TWR);
        mem_we    = (st_q == ST_DWR) || (st_q == ST_TWR);
        mem_addr  = ((st_q == ST_DRD) || (st_q == ST_DWR)) ? dir_slot : tab_slot;
        mem_wdata = (st_q == ST_DWR) ? pde_q : pte_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            rq_q   <= '0;
            res_q  <= '0;
            base_q <= '0;
            pde_q  <= '0;
            pte_q  <= '0;
            flt_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        rq_q   <= '{lin: req_lin, wr: req_write, user: req_user};
                        base_q <= dir_base;
                        if (pg_en) begin
                            st_q <= ST_DRD;
                        end else begin
                            res_q <= '{fault: 1'b0, prot: 1'b0, phys: req_lin};
                            st_q  <= ST_RESP;
                        end
                    end
                end
                ST_DRD: begin
                    if (mem_ack) begin
                        pde_q <= pde_upd;
                        if (!pde_present) begin
                            res_q <= '{fault: 1'b1, prot: 1'b0, phys: '0};
                            flt_q <= rq_q.lin;
                            st_q  <= ST_RESP;
                        end else begin
                            st_q <= pde_chg ? ST_DWR : ST_TRD;
                        end
                    end
                end
                ST_DWR: begin
                    if (mem_ack) st_q <= ST_TRD;
                end
                ST_TRD: begin
                    if (mem_ack) begin
                        if (!pte_present || perm_deny) begin
                            res_q <= '{fault: 1'b1, prot: pte_present, phys: '0};
                            flt_q <= rq_q.lin;
                            st_q  <= ST_RESP;
                        end else begin
                            pte_q <= pte_upd;
                            res_q <= '{fault: 1'b0, prot: 1'b0,
                                       phys: {mem_rdata[ADDR_W-1:OFF_W], rq_q.lin[OFF_W-1:0]}};
                            st_q  <= pte_chg ? ST_TWR : ST_RESP;
                        end
                    end
                end
                ST_TWR: begin
                    if (mem_ack) st_q <= ST_RESP;
                end
                ST_RESP: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (st_q == ST_IDLE);
    assign rsp_valid  = (st_q == ST_RESP);
    assign rsp_phys   = res_q.phys;
    assign rsp_fault  = res_q.fault;
    assign rsp_prot   = res_q.prot;
    assign rsp_vector = (rsp_valid && res_q.fault) ? FAULT_VECTOR : '0;
    assign fault_lin  = flt_q;
    assign wr_q       = rq_q.wr;
    assign user_q     = rq_q.user;
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pg_en,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_lin,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_phys,
    output logic              rsp_fault,
    output logic              rsp_prot,
    output logic [VEC_W-1:0]  rsp_vector,
    output logic [ADDR_W-1:0] fault_lin,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic              pde_present, pte_present;
    logic              pde_chg, pte_chg;
    logic [ADDR_W-1:0] pde_upd, pte_upd, pde_q;
    logic              wr_q, user_q, perm_deny;

    xlate_entry_eval #(.IS_LEAF(1'b0)) u_dir_eval (
        .entry(mem_rdata), .wr(wr_q),
        .present(pde_present), .upd(pde_upd), .changed(pde_chg)
    );

    xlate_entry_eval #(.IS_LEAF(1'b1)) u_tab_eval (
        .entry(mem_rdata), .wr(wr_q),
        .present(pte_present), .upd(pte_upd), .changed(pte_chg)
    );

    xlate_perm u_perm (
        .user(user_q), .wr(wr_q), .dir_ent(pde_q), .tab_ent(mem_rdata),
        .deny(perm_deny)
    );

    xlate_seq u_seq (
        .clk(clk), .rst(rst), .pg_en(pg_en), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .pde_present(pde_present), .pde_upd(pde_upd), .pde_chg(pde_chg),
        .pte_present(pte_present), .pte_upd(pte_upd), .pte_chg(pte_chg),
        .perm_deny(perm_deny), .wr_q(wr_q), .user_q(user_q), .pde_q(pde_q),
        .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
        .rsp_prot(rsp_prot), .rsp_vector(rsp_vector), .fault_lin(fault_lin)
    );
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk
    import xlate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pg_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_lin,
    input logic              req_write,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_phys,
    input logic              rsp_fault,
    input logic [VEC_W-1:0]  rsp_vector,
    input logic [ADDR_W-1:0] fault_lin,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic [ADDR_W-1:0] mem_rdata,
    input logic              mem_ack
);
    logic [ADDR_W-1:0] held_lin, rd_data_q, rd_addr_q;
    logic              held_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_lin  <= '0;
            held_wr   <= 1'b0;
            rd_data_q <= '0;
            rd_addr_q <= '0;
        end else begin
            if (req_valid && req_ready) begin
                held_lin <= req_lin;
                held_wr  <= req_write;
            end
            if (mem_req && !mem_we && mem_ack) begin
                rd_data_q <= mem_rdata;
                rd_addr_q <= mem_addr;
            end
        end
    end

    // R5
    bypass_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !pg_en) |=>
            (rsp_valid && !rsp_fault && rsp_phys == $past(req_lin)));

    // R3
    fault_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_vector == FAULT_VECTOR));

    // R4
    fault_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (fault_lin == held_lin));

    // R4
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fault_lin) |-> (rsp_valid && rsp_fault));

    // R2
    offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_phys[OFF_W-1:0] == held_lin[OFF_W-1:0]));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req);

    // R6
    accessed_set_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[FL_ACCESS]);

    // R8
    wb_change_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata != rd_data_q && mem_addr == rd_addr_q));

    // R7
    dirty_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_wdata[FL_DIRTY] && !rd_data_q[FL_DIRTY]) |-> held_wr);
endmodule

bind xlate_walker xlate_walker_chk u_chk (
    .clk(clk), .rst(rst), .pg_en(pg_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_lin(req_lin), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
    .rsp_vector(rsp_vector), .fault_lin(fault_lin), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
);

// File: tb/xlate_walker_bench.sv
module xlate_walker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pg_en = 1'b1;
    logic [31:0] dir_base = 32'h0001_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid, rsp_fault, rsp_prot;
    logic [31:0] rsp_phys, fault_lin;
    logic [7:0]  rsp_vector;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack;

    int checks = 0;
    int fails = 0;
    int acc_cnt = 0;
    int cyc = 0;

    logic [31:0] store [128];

    always #10 clk = ~clk;

    function automatic logic slot_ok(input logic [31:0] a);
        return (a[31:18] == '0) && (a[15:13] == '0) && (a[11:6] == '0) && (a[1:0] == '0);
    endfunction
    function automatic int slot_ix(input logic [31:0] a);
        return int'({a[17:16], a[12], a[5:2]});
    endfunction

    assign mem_ack   = mem_req;
    assign mem_rdata = slot_ok(mem_addr) ? store[slot_ix(mem_addr)] : 32'h0;

    always @(negedge clk) begin
        if (mem_req) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_we && slot_ok(mem_addr)) store[slot_ix(mem_addr)] <= mem_wdata;
        end
    end

    xlate_walker u_xlate_walker (
        .clk(clk), .rst(rst), .pg_en(pg_en), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
        .rsp_prot(rsp_prot), .rsp_vector(rsp_vector), .fault_lin(fault_lin),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // {lin, write, user, fault, prot, phys, accesses}
    localparam int NV = 11;
    localparam logic [71:0] VEC [NV] = '{
        {32'h0040_0123, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0005_0123, 4'd4},
        {32'h0040_0456, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0005_0456, 4'd3},
        {32'h0040_0789, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0005_0789, 4'd2},
        {32'h0040_2ABC, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0007_0ABC, 4'd2},
        {32'h0040_1000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 4'd2},
        {32'h00C0_0010, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 4'd1},
        {32'h0080_0F00, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'd2},
        {32'h0080_0F00, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0008_0F00, 4'd3},
        {32'h0040_3004, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'd2},
        {32'h0040_3004, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0009_0004, 4'd2},
        {32'h0040_3004, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0009_0004, 4'd3}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [31:0] lin, input logic wr, input logic usr,
                           output logic got);
        @(negedge clk);
        req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr;
        acc_cnt = 0;
        @(negedge clk);
        req_valid = 1'b0;
        // R10: busy once accepted with paging on
        if (pg_en) check("R10 ready low while walking", {31'b0, req_ready}, 32'h0);
        got = 1'b0;
        for (int k = 0; k < 40 && !got; k++) begin
            if (rsp_valid) got = 1'b1;
            else @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            fails++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic got;
        for (int i = 0; i < 128; i++) store[i] = '0;
        store[slot_ix(32'h0001_0004)] = 32'h0002_0007;
        store[slot_ix(32'h0001_0008)] = 32'h0002_1021;
        store[slot_ix(32'h0001_000C)] = 32'h0000_0000;
        store[slot_ix(32'h0002_0000)] = 32'h0005_0007;
        store[slot_ix(32'h0002_0004)] = 32'h0006_0000;
        store[slot_ix(32'h0002_0008)] = 32'h0007_0067;
        store[slot_ix(32'h0002_000C)] = 32'h0009_0025;
        store[slot_ix(32'h0002_1000)] = 32'h0008_0027;

        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 req_ready", {31'b0, req_ready}, 32'h1);
        check("R11 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check("R11 mem_req",   {31'b0, mem_req},   32'h0);
        check("R11 fault_lin", fault_lin, 32'h0);
        rst = 1'b0;

        // R1 R2 R3 R6 R7 R8 R9 vector walk
        for (int v = 0; v < NV; v++) begin
            logic [71:0] e;
            e = VEC[v];
            run_req(e[71:40], e[39], e[38], got);
            check($sformatf("R10 response v%0d", v), {31'b0, got}, 32'h1);
            check($sformatf("R3 R9 fault v%0d", v), {31'b0, rsp_fault}, {31'b0, e[37]});
            check($sformatf("R9 prot v%0d", v), {31'b0, rsp_prot}, {31'b0, e[36]});
            check($sformatf("R3 vector v%0d", v), {24'b0, rsp_vector}, e[37] ? 32'd14 : 32'd0);
            check($sformatf("R1 R2 phys v%0d", v), rsp_phys, e[35:4]);
            check($sformatf("R8 accesses v%0d", v), acc_cnt, {28'b0, e[3:0]});
        end

        // R4 fault address kept through later good walks
        check("R4 fault_lin held", fault_lin, 32'h0040_3004);
        // R6 accessed set in directory entry, kept afterwards
        check("R6 dir entry", store[slot_ix(32'h0001_0004)], 32'h0002_0027);
        check("R6 full entry untouched", store[slot_ix(32'h0002_0008)], 32'h0007_0067);
        // R7 dirty in table entries only
        check("R7 table dirty", store[slot_ix(32'h0002_0000)], 32'h0005_0067);
        check("R7 table dirty sup", store[slot_ix(32'h0002_1000)], 32'h0008_0067);
        check("R7 dir no dirty", store[slot_ix(32'h0001_0008)], 32'h0002_1021);
        check("R9 ro page dirty after sup write", store[slot_ix(32'h0002_000C)], 32'h0009_0065);

        // R5 paging disabled
        pg_en = 1'b0;
        run_req(32'hDEAD_BEEF, 1'b1, 1'b1, got);
        check("R5 response", {31'b0, got}, 32'h1);
        check("R5 phys", rsp_phys, 32'hDEAD_BEEF);
        check("R5 no fault", {31'b0, rsp_fault}, 32'h0);
        check("R5 no memory access", acc_cnt, 32'h0);
        check("R4 fault_lin after bypass", fault_lin, 32'h0040_3004);

        // R4 new fault replaces the address
        pg_en = 1'b1;
        run_req(32'h00C0_1234, 1'b0, 1'b0, got);
        check("R4 fault_lin replaced", fault_lin, 32'h00C0_1234);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule